// File: doc/BRIEF.md
# Omega Multistage Switching Fabric

This block is an N-by-N self-routing switch fabric for a many-port chip interconnect. It is made of log2(N) columns of 2x2 switch elements with N/2 elements per column. Ahead of every column sits a fixed perfect-shuffle wiring, which rotates the lane index left by one bit. Every input port offers a packet made of a valid bit, a destination port number and a data word. Each element sets itself from one bit of the destination, so every packet steers itself to its output port. The total element count is (N/2)*log2(N), so the cost grows as N log N.

Not every permutation can be routed through this topology. When two packets need the same internal link, the one on the upper element input takes the link and the other is dropped. The fabric raises a blocked flag on the dropped packet's source port, and the source decides whether to retry. Each element can also be forced to copy one of its inputs onto both of its outputs, which gives broadcast and multicast patterns.

The stream side carries a valid bit only. The fabric applies no back-pressure and accepts a fresh set of packets on every clock. A packet that is not delivered is reported through its blocked flag and is never held back. Delivered packets and blocked flags are registered once, so they appear together one clock after the inputs.

Top module: `omega_fabric`

## Requirements
- R1: The fabric has log2(N) stages of N/2 2x2 elements. Before each stage the lanes are permuted by a perfect shuffle: lane p feeds lane rotate-left(p). Element s of a stage takes lane 2s as its upper input and lane 2s+1 as its lower input.
- R2: With automatic settings, stage k (0 at the input side) sends a packet to the element's upper output when destination bit log2(N)-1-k is 0, and to the lower output when that bit is 1. A lone packet from any source therefore arrives at its destination port with its data unchanged.
- R3: A full permutation, such as identity, bit reversal or a random one, gives per-port delivery and blocking exactly as a stage-by-stage trace of R1, R2 and R4 predicts. The identity permutation is delivered with no blocking.
- R4: If both inputs of an element want the same output, the upper input wins. The lower packet is dropped for the rest of the fabric and its source's blocked flag is set. For N=8, source 2 to port 7 together with source 6 to port 4 delivers only source 2's data at port 7 and blocks source 6.
- R5: An element with one valid input routes that input by R2. An element with no valid input drives invalid outputs. An output port that receives no packet shows out_valid low.
- R6: Switch override field f = k*(N/2)+s occupies sw_force[2f+1:2f]. Values 0 and 1 select automatic routing. Value 2 copies the upper input to both outputs. Value 3 copies the lower input to both outputs. In a broadcast setting, a valid packet on the discarded input is dropped and its source is flagged blocked. A source is flagged when any of its copies is dropped.
- R7: out_valid, out_data and src_blocked show the result for the inputs sampled one clock edge earlier. src_blocked is never set for a source whose in_valid was low.
- R8: While rst_n is low, all out_valid and src_blocked bits are 0.
- R9: With all elements automatic, the number of delivered packets plus the number of blocked sources equals the number of valid inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Per-source packet valid |
| in_dest | input | N*log2(N) | Destination port per source, source i at [i*log2(N) +: log2(N)] |
| in_data | input | N*W | Data word per source, source i at [i*W +: W] |
| sw_force | input | 2*(N/2)*log2(N) | Per-element setting override (R6) |
| out_valid | output | N | Per-output-port packet valid, registered |
| out_data | output | N*W | Data per output port, registered |
| src_blocked | output | N | Per-source drop flag, registered, same cycle as outputs |

## Verification
Every result of this fabric is due exactly one clock edge after its inputs. This covers the delivered packets, the empty output ports and the blocked flags on the source side. The bench applies a vector just after a falling edge and reads all outputs at the next falling edge, so exactly one rising edge lies between stimulus and check. It changes the inputs only after that read. The expected values come from a bench trace that walks each packet lane by lane through the shuffles and elements. That trace predicts collisions, broadcast copies and which sources are dropped.

// File: rtl/omega_pkg.sv
package omega_pkg;
  // per-element setting override
  typedef enum logic [1:0] {
    SW_AUTO     = 2'd0,
    SW_AUTO_ALT = 2'd1,
    SW_BC_UP    = 2'd2,
    SW_BC_LO    = 2'd3
  } sw_mode_e;

  function automatic int clog2i(input int n);
    int r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction
endpackage

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic [1:0]      vin,
  input  logic [2*AW-1:0] din,
  input  logic [2*W-1:0]  xin,
  input  logic [2*AW-1:0] sin,
  input  logic [1:0]      rbit,   // steering bit per input (0 = upper out)
  input  logic [1:0]      mode,
  output logic [1:0]      vout,
  output logic [2*AW-1:0] dout,
  output logic [2*W-1:0]  xout,
  output logic [2*AW-1:0] sout,
  output logic [1:0]      lose
);
  always_comb begin
    vout = '0;
    dout = '0;
    xout = '0;
    sout = '0;
    lose = '0;
    case (sw_mode_e'(mode))
      SW_BC_UP, SW_BC_LO: begin
        // one input copied to both outputs; the other is discarded
        for (int o = 0; o < 2; o++) begin
          vout[o]           = vin[mode[0]];
          dout[o*AW +: AW]  = din[mode[0]*AW +: AW];
          xout[o*W +: W]    = xin[mode[0]*W +: W];
          sout[o*AW +: AW]  = sin[mode[0]*AW +: AW];
        end
        lose[~mode[0]] = vin[~mode[0]];
      end
      default: begin
        for (int i = 0; i < 2; i++) begin
          if (vin[i]) begin
            if (vout[rbit[i]]) begin
              lose[i] = 1'b1;      // upper already holds this output
            end else begin
              vout[rbit[i]]          = 1'b1;
              dout[rbit[i]*AW +: AW] = din[i*AW +: AW];
              xout[rbit[i]*W +: W]   = xin[i*W +: W];
              sout[rbit[i]*AW +: AW] = sin[i*AW +: AW];
            end
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N = 8,
  parameter int W = 8,
  parameter int K = 0,
  localparam int AW = omega_pkg::clog2i(N),
  localparam int H  = N / 2
) (
  input  logic [N-1:0]    vin,
  input  logic [N*AW-1:0] din,
  input  logic [N*W-1:0]  xin,
  input  logic [N*AW-1:0] sin,
  input  logic [2*H-1:0]  ctl,
  output logic [N-1:0]    vout,
  output logic [N*AW-1:0] dout,
  output logic [N*W-1:0]  xout,
  output logic [N*AW-1:0] sout,
  output logic [N-1:0]    drop_mask
);
  logic [N-1:0]    sv;
  logic [N*AW-1:0] sd;
  logic [N*W-1:0]  sx;
  logic [N*AW-1:0] ss;
  logic [N-1:0]    lose;

  // perfect shuffle: lane j is fed by lane rotate-right(j)
  for (genvar j = 0; j < N; j++) begin : g_shuf
    localparam int P = (j >> 1) | ((j & 1) << (AW - 1));
    assign sv[j]            = vin[P];
    assign sd[j*AW +: AW]   = din[P*AW +: AW];
    assign sx[j*W +: W]     = xin[P*W +: W];
    assign ss[j*AW +: AW]   = sin[P*AW +: AW];
  end

  for (genvar s = 0; s < H; s++) begin : g_sw
    logic [1:0] rb;
    assign rb = {sd[(2*s+1)*AW + AW-1-K], sd[(2*s)*AW + AW-1-K]};
    omega_switch #(.W(W), .AW(AW)) u_sw (
      .vin (sv[2*s +: 2]),
      .din (sd[2*s*AW +: 2*AW]),
      .xin (sx[2*s*W +: 2*W]),
      .sin (ss[2*s*AW +: 2*AW]),
      .rbit(rb),
      .mode(ctl[2*s +: 2]),
      .vout(vout[2*s +: 2]),
      .dout(dout[2*s*AW +: 2*AW]),
      .xout(xout[2*s*W +: 2*W]),
      .sout(sout[2*s*AW +: 2*AW]),
      .lose(lose[2*s +: 2])
    );
  end

  // map lane losses back to the source port that sent them
  always_comb begin
    drop_mask = '0;
    for (int j = 0; j < N; j++)
      if (lose[j]) drop_mask[ss[j*AW +: AW]] = 1'b1;
  end
endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int AW = omega_pkg::clog2i(N),
  localparam int H  = N / 2,
  localparam int NSW = H * AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      in_valid,
  input  logic [N*AW-1:0]   in_dest,
  input  logic [N*W-1:0]    in_data,
  input  logic [2*NSW-1:0]  sw_force,
  output logic [N-1:0]      out_valid,
  output logic [N*W-1:0]    out_data,
  output logic [N-1:0]      src_blocked
);
  logic [N-1:0]    lv [AW+1];
  logic [N*AW-1:0] ld [AW+1];
  logic [N*W-1:0]  lx [AW+1];
  logic [N*AW-1:0] ls [AW+1];
  logic [N-1:0]    dm [AW];
  logic [N-1:0]    blk_c;

  assign lv[0] = in_valid;
  assign ld[0] = in_dest;
  assign lx[0] = in_data;
  for (genvar i = 0; i < N; i++) begin : g_src
    assign ls[0][i*AW +: AW] = AW'(i);
  end

  for (genvar k = 0; k < AW; k++) begin : g_stage
    omega_stage #(.N(N), .W(W), .K(k)) u_stage (
      .vin      (lv[k]),
      .din      (ld[k]),
      .xin      (lx[k]),
      .sin      (ls[k]),
      .ctl      (sw_force[2*H*k +: 2*H]),
      .vout     (lv[k+1]),
      .dout     (ld[k+1]),
      .xout     (lx[k+1]),
      .sout     (ls[k+1]),
      .drop_mask(dm[k])
    );
  end

  always_comb begin
    blk_c = '0;
    for (int k = 0; k < AW; k++) blk_c |= dm[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= '0;
      out_data    <= '0;
      src_blocked <= '0;
    end else begin
      out_valid   <= lv[AW];
      out_data    <= lx[AW];
      src_blocked <= blk_c;
    end
  end
endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int AW = omega_pkg::clog2i(N),
  localparam int NSW = (N / 2) * AW
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     in_valid,
  input logic [2*NSW-1:0] sw_force,
  input logic [N-1:0]     out_valid,
  input logic [N-1:0]     src_blocked
);
  logic armed;
  logic all_auto;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    all_auto = 1'b1;
    for (int f = 0; f < NSW; f++) if (sw_force[2*f+1]) all_auto = 1'b0;
  end

  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (out_valid == '0 && src_blocked == '0));

  a_r7_blocked_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((src_blocked & ~$past(in_valid)) == '0));

  a_r9_conservation: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(all_auto)) |->
      ($countones(out_valid) + $countones(src_blocked) == $past($countones(in_valid))));

  a_r5_lone_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(all_auto) && $past($countones(in_valid) == 1)) |->
      (src_blocked == '0 && $countones(out_valid) == 1));
endmodule

bind omega_fabric omega_fabric_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sw_force(sw_force),
  .out_valid(out_valid), .src_blocked(src_blocked)
);

// File: tb/tb_omega_fabric.sv
module tb_omega_fabric;
  localparam int N = 8;
  localparam int W = 8;
  localparam int AW = 3;
  localparam int H = N / 2;
  localparam int NSW = H * AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     in_valid = '0;
  logic [N*AW-1:0]  in_dest = '0;
  logic [N*W-1:0]   in_data = '0;
  logic [2*NSW-1:0] sw_force = '0;
  logic [N-1:0]     out_valid;
  logic [N*W-1:0]   out_data;
  logic [N-1:0]     src_blocked;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  omega_fabric #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .sw_force(sw_force), .out_valid(out_valid),
    .out_data(out_data), .src_blocked(src_blocked)
  );

  // expected results from the bench trace
  logic [N-1:0]   ev;
  logic [N*W-1:0] ex;
  logic [N-1:0]   eb;

  // lane-by-lane trace of shuffle and element decisions (R1, R2, R4, R6)
  task automatic trace();
    logic [N-1:0] v, nv;
    int d [N]; int x [N]; int s [N];
    int nd [N]; int nx [N]; int ns [N];
    eb = '0;
    for (int i = 0; i < N; i++) begin
      v[i] = in_valid[i]; d[i] = in_dest[i*AW +: AW];
      x[i] = in_data[i*W +: W]; s[i] = i;
    end
    for (int k = 0; k < AW; k++) begin
      for (int j = 0; j < N; j++) begin
        int p;
        p = (j >> 1) | ((j & 1) << (AW - 1));
        nv[j] = v[p]; nd[j] = d[p]; nx[j] = x[p]; ns[j] = s[p];
      end
      for (int sw = 0; sw < H; sw++) begin
        int m, u;
        m = sw_force[2*(k*H+sw) +: 2];
        u = 2 * sw;
        if (m >= 2) begin
          int keep, drop;
          keep = (m == 3) ? u + 1 : u;
          drop = (m == 3) ? u : u + 1;
          if (nv[drop]) eb[ns[drop]] = 1'b1;
          for (int o = 0; o < 2; o++) begin
            v[u+o] = nv[keep]; d[u+o] = nd[keep]; x[u+o] = nx[keep]; s[u+o] = ns[keep];
          end
        end else begin
          v[u] = 1'b0; v[u+1] = 1'b0;
          d[u] = 0; d[u+1] = 0; x[u] = 0; x[u+1] = 0; s[u] = 0; s[u+1] = 0;
          for (int i = 0; i < 2; i++) begin
            if (nv[u+i]) begin
              int o;
              o = (nd[u+i] >> (AW - 1 - k)) & 1;
              if (v[u+o]) eb[ns[u+i]] = 1'b1;
              else begin
                v[u+o] = 1'b1; d[u+o] = nd[u+i]; x[u+o] = nx[u+i]; s[u+o] = ns[u+i];
              end
            end
          end
        end
      end
    end
    ev = v;
    ex = '0;
    for (int i = 0; i < N; i++) if (v[i]) ex[i*W +: W] = W'(x[i]);
  endtask

  task automatic check(input string tag);
    logic ok;
    ok = (out_valid == ev) && (src_blocked == eb);
    for (int i = 0; i < N; i++)
      if (ev[i] && out_data[i*W +: W] != ex[i*W +: W]) ok = 1'b0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: valid=%b data=%h blocked=%b expected valid=%b data=%h blocked=%b",
               tag, out_valid, out_data & mask_data(out_valid), src_blocked,
               ev, ex, eb);
    end
  endtask

  function automatic logic [N*W-1:0] mask_data(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) mask_data[i*W +: W] = m[i] ? {W{1'b1}} : '0;
  endfunction

  // apply one vector after a falling edge, check at the next falling edge (R7)
  task automatic apply(input string tag);
    trace();
    @(negedge clk);
    check(tag);
  endtask

  task automatic set_pkt(input int src, input int dst, input int dat);
    in_valid[src] = 1'b1;
    in_dest[src*AW +: AW] = AW'(dst);
    in_data[src*W +: W] = W'(dat);
  endtask

  task automatic clear_in();
    in_valid = '0; in_dest = '0; in_data = '0; sw_force = '0;
  endtask

  task automatic rand_perm();
    int pm [N];
    for (int i = 0; i < N; i++) pm[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int j, t;
      j = $urandom_range(i, 0);
      t = pm[i]; pm[i] = pm[j]; pm[j] = t;
    end
    for (int i = 0; i < N; i++) set_pkt(i, pm[i], $urandom_range(255, 0));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R7: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // R8: held in reset
    repeat (3) @(negedge clk);
    total++;
    if (out_valid != '0 || src_blocked != '0) begin
      bad++;
      $display("FAIL R8: valid=%b blocked=%b expected 0/0", out_valid, src_blocked);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R5: lone packets from every source to every port
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        clear_in(); set_pkt(s, d, 16 * s + d + 1); apply("R2 lone packet");
      end

    // R5: nothing valid
    clear_in(); in_data = '1; apply("R5 empty fabric");

    // R4: upper wins at a shared link
    clear_in(); set_pkt(2, 7, 8'hA5); set_pkt(6, 4, 8'h5A);
    apply("R4 collision example");
    total++;
    if (!(out_valid == 8'b1000_0000 && out_data[7*W +: W] == 8'hA5 && src_blocked == 8'b0100_0000)) begin
      bad++;
      $display("FAIL R4: valid=%b blocked=%b expected 10000000/01000000", out_valid, src_blocked);
    end

    // R3: identity, no blocking
    clear_in();
    for (int i = 0; i < N; i++) set_pkt(i, i, 8'h30 + i);
    apply("R3 identity");
    total++;
    if (out_valid != '1 || src_blocked != '0) begin
      bad++;
      $display("FAIL R3 identity: valid=%b blocked=%b expected 11111111/00000000", out_valid, src_blocked);
    end

    // R3: bit reversal
    clear_in();
    for (int i = 0; i < N; i++) set_pkt(i, {i[0], i[1], i[2]}, 8'h70 + i);
    apply("R3 bit reversal");

    // R3, R9: random full permutations
    for (int t = 0; t < 60; t++) begin
      clear_in(); rand_perm(); apply("R3 random permutation");
    end

    // R5, R9: random partial traffic with free destinations (R1 routing)
    for (int t = 0; t < 60; t++) begin
      clear_in();
      for (int i = 0; i < N; i++)
        if ($urandom_range(1, 0) == 1) set_pkt(i, $urandom_range(N - 1, 0), $urandom_range(255, 0));
      apply("R1 R5 partial traffic");
    end

    // R6: directed upper broadcast on the last stage, element 0
    clear_in();
    for (int i = 0; i < N; i++) set_pkt(i, i, 8'hC0 + i);
    sw_force[2*(2*H+0) +: 2] = 2'd2;
    apply("R6 upper broadcast");
    clear_in();
    for (int i = 0; i < N; i++) set_pkt(i, i, 8'hD0 + i);
    sw_force[2*(0*H+1) +: 2] = 2'd3;
    apply("R6 lower broadcast");

    // R6: random overrides
    for (int t = 0; t < 60; t++) begin
      clear_in(); rand_perm();
      for (int f = 0; f < NSW; f++) sw_force[2*f +: 2] = 2'($urandom_range(3, 0));
      apply("R6 random override");
    end

    // R7: back-to-back vectors each seen one edge later
    for (int t = 0; t < 10; t++) begin
      clear_in(); set_pkt(t % N, (t * 5) % N, t + 9); apply("R7 latency");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule